// File: doc/BRIEF.md
# Buffer-Fill Phase Smoothing Loop

This block is a small digital phase-locked loop that generates the read-side bit enable for an elastic bit buffer. It watches bit 3 of the buffer's write address counter (inverted) and bit 3 of its read address counter. It moves the read rate so that the rising edges of these two signals line up, which happens when the buffer holds exactly half its depth. When a framing stage adds or removes a single write pulse (positive or negative stuffing), the reference edge moves by one bit. The loop then moves the read phase toward it gradually instead of in one step, so the output bit clock never jumps.

A phase detector measures the signed number of system clocks between the two rising edges. A first-order loop filter scales that measurement into a frequency offset, using a gain shift that depends on the mode. A 32-bit phase accumulator adds the nominal increment plus that offset on every clock and emits a one-clock read enable on each carry. The nominal increment comes from a five-entry rate table. Normal mode absorbs a one-bit step in roughly a thousand bit times. Narrowband mode takes roughly twenty thousand.

Top module: `fill_smooth_pll`

## Requirements
- R1: While rst_ni is low, rd_en_o is low and the accumulator is cleared. With rate code 0 and CLK_HZ four times 153.6 kHz, the first read enable appears in the cycle after the fourth rising clock edge following reset release.
- R2: With no detector edges, the read enable rate is the nominal rate of rate_sel_i: 0 = 153.6 kHz, 1 = 76.8 kHz, 2 = 50 kHz, 3 = 38.4 kHz, 4 to 7 = 19.2 kHz. The rate is the same in both modes. Over N clocks the count of enables is within one of N*rate/CLK_HZ.
- R3: The detector acts only on rising edges of the inverted write bit 3 (reference) and the read bit 3 (variable). When these edges fall in the same cycle, no correction is applied. A buffer driven at the nominal rate then stays exactly half full (fill 8 of 16).
- R4: rd_en_o is high for one clock at a time whenever the increment is below half the accumulator range.
- R5: After one extra write pulse, the read rate is raised until the edges coincide again. The fill returns to 8 and never leaves 7 to 9.
- R6: After one missing write pulse, the read rate is lowered until the edges coincide again. The fill returns to 8 and never leaves 7 to 9.
- R7: With narrow_i low and 4 clocks per bit, a one-bit step is absorbed in 600 to 1,600 bit times. This is measured to the last non-coincident edge pair.
- R8: With narrow_i high, the same step takes 12,000 to 22,000 bit times and at least eight times as long as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_bit3_i | input | 1 | Bit 3 of the buffer write address counter |
| rd_bit3_i | input | 1 | Bit 3 of the buffer read address counter |
| rate_sel_i | input | 3 | Nominal output rate code |
| narrow_i | input | 1 | 1 selects narrowband (slow) loop gain |
| rd_en_o | output | 1 | One-clock read enable per output bit |

## Verification
The bench closes the loop with a model of a 16-entry buffer's two address counters, with writes at exactly the nominal rate. After the loop pulls in from reset, the bench checks that the fill stays constant at half depth, which separates a true edge-coincidence lock from a loop that only averages to the right rate. It then applies one positive stuff and one negative stuff in normal mode and one positive stuff in narrowband mode. It measures the settling interval and the fill excursion, which catches a wrong error sign, a wrong gain per mode and overshoot. A sweep of all eight rate codes in both modes, with the counter bits held still, confirms the nominal increment table apart from any loop action.

// File: rtl/fill_pll_pkg.sv
package fill_pll_pkg;

  localparam int RATE_SEL_W = 3;
  localparam int ACC_W      = 32;

  typedef enum logic [1:0] {PD_IDLE, PD_REF_LEAD, PD_VAR_LEAD} pd_state_e;

  function automatic longint unsigned rate_hz(input logic [RATE_SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 64'd153600;
      3'd1:    return 64'd76800;
      3'd2:    return 64'd50000;
      3'd3:    return 64'd38400;
      default: return 64'd19200;
    endcase
  endfunction

  // 2^32 * rate / clk
  function automatic logic [ACC_W-1:0] nominal_inc(input logic [RATE_SEL_W-1:0] sel,
                                                   input longint unsigned clk_hz);
    longint unsigned num;
    num = rate_hz(sel) << ACC_W;
    return ACC_W'(num / clk_hz);
  endfunction

  // log2 of clocks per bit, rounded at sqrt(2)
  function automatic int cpb_log2(input logic [RATE_SEL_W-1:0] sel,
                                  input longint unsigned clk_hz);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++)
      if ((rate_hz(sel) * 64'd1000) << i <= clk_hz * 64'd1414) r = i;
    return r;
  endfunction

endpackage

// File: rtl/fill_pll_phase_det.sv
module fill_pll_phase_det
  import fill_pll_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ref_i,
  input  logic                    var_i,
  output logic                    err_vld_o,
  output logic signed [ERR_W-1:0] err_o
);

  localparam int CNT_W = ERR_W - 1;

  logic             primed_q, ref_q, var_q;
  logic             ref_rise, var_rise;
  pd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign ref_rise = primed_q & ref_i & ~ref_q;
  assign var_rise = primed_q & var_i & ~var_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      ref_q    <= 1'b0;
      var_q    <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      ref_q    <= ref_i;
      var_q    <= var_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PD_IDLE;
      cnt_q     <= '0;
      err_vld_o <= 1'b0;
      err_o     <= '0;
    end else begin
      err_vld_o <= 1'b0;
      case (state_q)
        PD_IDLE: begin
          if (ref_rise && var_rise) begin
            err_vld_o <= 1'b1;
            err_o     <= '0;
          end else if (ref_rise) begin
            state_q <= PD_REF_LEAD;
            cnt_q   <= CNT_W'(1);
          end else if (var_rise) begin
            state_q <= PD_VAR_LEAD;
            cnt_q   <= CNT_W'(1);
          end
        end
        PD_REF_LEAD: begin
          if (var_rise) begin
            err_vld_o <= 1'b1;
            err_o     <= $signed({1'b0, cnt_q});
            state_q   <= PD_IDLE;
          end else if (ref_rise) begin
            cnt_q <= CNT_W'(1);
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PD_VAR_LEAD: begin
          if (ref_rise) begin
            err_vld_o <= 1'b1;
            err_o     <= -$signed({1'b0, cnt_q});
            state_q   <= PD_IDLE;
          end else if (var_rise) begin
            cnt_q <= CNT_W'(1);
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PD_IDLE;
      endcase
    end
  end

  p_zero_on_coincide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_IDLE && ref_rise && var_rise) |=> (err_vld_o && err_o == '0));

  p_meas_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |=> !err_vld_o);

endmodule

// File: rtl/fill_pll_filter.sv
module fill_pll_filter
  import fill_pll_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int          ERR_W        = 16,
  parameter int          NORMAL_SHIFT = 5,
  parameter int          NARROW_SHIFT = 9,
  parameter int          PER_LOG2     = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [RATE_SEL_W-1:0]   rate_sel_i,
  input  logic                    narrow_i,
  input  logic                    err_vld_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [ACC_W-1:0]        inc_o
);

  localparam int PROD_W = ERR_W + ACC_W + 1;

  logic [ACC_W-1:0]         nom;
  int                       sh;
  logic signed [PROD_W-1:0] prod, scaled;
  logic [ACC_W-1:0]         offset_q;

  always_comb begin
    nom    = nominal_inc(rate_sel_i, longint'(CLK_HZ));
    sh     = PER_LOG2 + cpb_log2(rate_sel_i, longint'(CLK_HZ))
           + (narrow_i ? NARROW_SHIFT : NORMAL_SHIFT);
    prod   = PROD_W'(err_i) * $signed({1'b0, nom});
    scaled = prod >>> sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        offset_q <= '0;
    else if (err_vld_i) offset_q <= scaled[ACC_W-1:0];
  end

  assign inc_o = nom + offset_q;

  p_hold_between_meas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_i |=> ($stable(inc_o) || !$stable(rate_sel_i) || !$stable(narrow_i)));

  p_zero_err_nominal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && err_i == '0) |=>
      (inc_o == nominal_inc(rate_sel_i, longint'(CLK_HZ)) || !$stable(rate_sel_i)));

endmodule

// File: rtl/fill_pll_nco.sv
module fill_pll_nco
  import fill_pll_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             rd_en_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      rd_en_o <= 1'b0;
    end else begin
      acc_q   <= sum[ACC_W-1:0];
      rd_en_o <= sum[ACC_W];
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !inc_i[ACC_W-1]) |=> (!rd_en_o || inc_i[ACC_W-1]));

endmodule

// File: rtl/fill_smooth_pll.sv
module fill_smooth_pll
  import fill_pll_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int          ERR_W        = 16,
  parameter int          NORMAL_SHIFT = 5,
  parameter int          NARROW_SHIFT = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_bit3_i,
  input  logic       rd_bit3_i,
  input  logic [2:0] rate_sel_i,
  input  logic       narrow_i,
  output logic       rd_en_o
);

  // counter bit 3 toggles every 8 bits: one edge per 16 bits
  localparam int PER_LOG2 = 4;

  logic                    err_vld;
  logic signed [ERR_W-1:0] err;
  logic [ACC_W-1:0]        inc;

  fill_pll_phase_det #(.ERR_W(ERR_W)) u_pd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (~wr_bit3_i),
    .var_i     (rd_bit3_i),
    .err_vld_o (err_vld),
    .err_o     (err)
  );

  fill_pll_filter #(
    .CLK_HZ       (CLK_HZ),
    .ERR_W        (ERR_W),
    .NORMAL_SHIFT (NORMAL_SHIFT),
    .NARROW_SHIFT (NARROW_SHIFT),
    .PER_LOG2     (PER_LOG2)
  ) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sel_i (rate_sel_i),
    .narrow_i   (narrow_i),
    .err_vld_i  (err_vld),
    .err_i      (err),
    .inc_o      (inc)
  );

  fill_pll_nco u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .rd_en_o (rd_en_o)
  );

endmodule

// File: tb/fill_smooth_pll_test.sv
module fill_smooth_pll_test;

  localparam int unsigned CLK_HZ = 614_400;  // 4 clocks per bit at 153.6 kHz

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_b3, rd_b3;
  logic [2:0] rate_sel;
  logic       narrow;
  logic       rd_en;

  always #5 clk = ~clk;

  fill_smooth_pll #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_bit3_i  (wr_b3),
    .rd_bit3_i  (rd_b3),
    .rate_sel_i (rate_sel),
    .narrow_i   (narrow),
    .rd_en_o    (rd_en)
  );

  int checks = 0;
  int errors = 0;

  bit         model_on = 1'b0;
  logic [3:0] wcnt = 4'd8;
  logic [3:0] rcnt = 4'd0;
  logic [1:0] tcnt = 2'd0;
  int         stuff = 0;
  bit         rd_seen = 1'b0;
  bit         rd_prev = 1'b0;
  int         dbl_pulses = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // buffer counter model
  initial begin
    wr_b3 = 1'b0;
    rd_b3 = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (model_on) begin
        if (rd_seen) rcnt = rcnt + 1'b1;
        tcnt = tcnt + 1'b1;
        if (tcnt == 2'd0) begin
          if (stuff < 0) stuff = 0;
          else wcnt = wcnt + 1'b1;
        end
        if (stuff > 0) begin
          wcnt  = wcnt + 1'b1;
          stuff = 0;
        end
      end
      wr_b3 = model_on ? wcnt[3] : 1'b0;
      rd_b3 = model_on ? rcnt[3] : 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      rd_seen = rd_en;
      if (rd_en && rd_prev) dbl_pulses++;
      rd_prev = rd_en;
    end
  end

  task automatic run_window(input int n, output int last_mis, output int fmin,
                            output int fmax, output int fend);
    logic pref, prd, cref, crd;
    logic [3:0] fill;
    last_mis = -1; fmin = 99; fmax = -1; fend = 0;
    pref = ~wr_b3;
    prd  = rd_b3;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cref = ~wr_b3;
      crd  = rd_b3;
      if ((cref && !pref) != (crd && !prd)) last_mis = i;
      fill = wcnt - rcnt;
      if (int'(fill) < fmin) fmin = int'(fill);
      if (int'(fill) > fmax) fmax = int'(fill);
      fend = int'(fill);
      pref = cref;
      prd  = crd;
    end
  endtask

  function automatic longint rate_of(input int code);
    case (code)
      0: return 153600;
      1: return 76800;
      2: return 50000;
      3: return 38400;
      default: return 19200;
    endcase
  endfunction

  initial begin
    repeat (199_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lm, fmn, fmx, fe, norm_bits, narr_bits;
    rst_n = 1'b0; rate_sel = 3'd0; narrow = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_en == 1'b0, "R1 idle in reset", rd_en, 0);

    // R1: first enable after the fourth edge
    rst_n = 1'b1;
    model_on = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(rd_en == (k == 4), "R1 first enable timing", rd_en, (k == 4));
    end

    // R3: pull in, then half-full lock
    run_window(8000, lm, fmn, fmx, fe);
    run_window(2048, lm, fmn, fmx, fe);
    check(lm == -1, "R3 edges coincide when locked", lm, -1);
    check(fmn == 8 && fmx == 8, "R3 fill constant at half", fmn * 100 + fmx, 808);

    // R5, R7: positive stuff, normal mode
    stuff = 1;
    run_window(8000, lm, fmn, fmx, fe);
    norm_bits = lm / 4;
    check(fmn >= 7 && fmx <= 9, "R5 fill excursion", fmn * 100 + fmx, 709);
    check(fe == 8, "R5 fill back at half", fe, 8);
    check(norm_bits >= 600 && norm_bits <= 1600, "R7 normal settle bits", norm_bits, 1000);

    // R6: negative stuff
    stuff = -1;
    run_window(8000, lm, fmn, fmx, fe);
    check(fmn >= 7 && fmx <= 9, "R6 fill excursion", fmn * 100 + fmx, 709);
    check(fe == 8, "R6 fill back at half", fe, 8);
    check(lm / 4 >= 600 && lm / 4 <= 1600, "R6 settle bits", lm / 4, 1000);

    // R8: narrowband
    narrow = 1'b1;
    stuff = 1;
    run_window(92000, lm, fmn, fmx, fe);
    narr_bits = lm / 4;
    check(fmn >= 7 && fmx <= 9, "R8 fill excursion", fmn * 100 + fmx, 709);
    check(fe == 8, "R8 fill back at half", fe, 8);
    check(narr_bits >= 12000 && narr_bits <= 22000, "R8 narrow settle bits", narr_bits, 20000);
    check(narr_bits >= 8 * norm_bits, "R8 narrow vs normal ratio", narr_bits, 8 * norm_bits);

    // R2: nominal rates, no detector edges
    model_on = 1'b0;
    for (int code = 0; code < 8; code++) begin
      for (int nm = 0; nm < 2; nm++) begin
        int cnt;
        longint exp;
        @(negedge clk);
        rst_n = 1'b0; rate_sel = 3'(code); narrow = nm[0];
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        repeat (1024) begin
          @(negedge clk);
          if (rd_en) cnt++;
        end
        exp = (64'd1024 * rate_of(code)) / CLK_HZ;
        check(cnt >= exp - 1 && cnt <= exp + 1, "R2 nominal rate count", cnt, exp);
      end
    end

    check(dbl_pulses == 0, "R4 single-cycle enables", dbl_pulses, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule